// File: doc/BRIEF.md
# Single-Cycle Instruction Control Decoder

This block turns the opcode and function fields of a 32-bit instruction into the control signals that steer a single-cycle datapath. It drives the register-destination select, the second-operand select, the load write-back select, the register and memory enables, the branch and jump strobes, the 2-bit ALU operation class and the 4-bit ALU function code. Two extra selects serve the added instructions. One routes a register value to the next-PC logic for jump-register. The other routes the instruction's shift-amount field into the ALU for shift-left-logical.

To make the decoder's effect visible, the top wraps it with a small execution slice. The slice holds a register file, an ALU and a word-addressed data store. It has no program counter and no instruction store. The bench supplies one instruction per cycle, and the results show up on the ALU result port and on the rs-operand port.

A fault-injection select can pin one control line to a constant: memory write at 1, ALU source at 1, or register write at 1. This shows how a stuck control wire corrupts architectural state.

Top module: `scdec_core`

## Requirements
- R1: Opcode 100011 (load) gives ALU-source=1, load write-back=1, register write=1, memory read=1, ALU class 00 and code 0010. Opcode 101011 (store) gives ALU-source=1, memory write=1, class 00 and code 0010. Opcode 000010 gives jump=1 with every enable at 0.
- R2: Opcode 000000 with function 100000/100010/100100/100101/100111/101010 gives reg-dst=1, register write=1 and class 10. The ALU code is 0010/0110/0000/0001/1100/0111 respectively (add, sub, and, or, nor, signed set-less-than), and the ALU result matches that operation on the rs and rt values.
- R3: Function 001000 under opcode 000000 (jump-register) gives jr-select=1 and the rs value on the rs-operand port. Register write, memory read, memory write and branch are all 0. jr-select is 0 for every other instruction.
- R4: Function 000000 under opcode 000000 (shift-left-logical) gives class 11, code 1110, shift select=1, reg-dst=1 and register write=1. The result is the rt value shifted left by instruction bits 10 to 6.
- R5: Any other opcode, or any other function under opcode 000000, raises the illegal flag and holds every write, read, branch and jump output at 0. Registers do not change.
- R6: Register 0 reads as zero whatever is written to it, including by the all-zero instruction.
- R7: Fault select 01 forces memory write to 1. Executing R-format, load or branch-equal then overwrites a data word.
- R8: Fault select 10 forces the ALU source to 1, so an R-format instruction adds the sign-extended low 16 instruction bits in place of rt.
- R9: Fault select 11 forces register write to 1. Store and branch-equal then overwrite register rt with the ALU result.
- R10: Opcode 000100 (branch-equal) gives branch=1, class 01 and code 0110. The zero flag is 1 exactly when rs equals rt.
- R11: A stored word reads back through a later load at the same address. After reset every register is zero and data word i holds 0x100 + 4*i. The word index is ALU result bits 5 to 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr | input | 32 | Instruction under execution |
| fault_sel | input | 2 | 00 none, 01 memory write stuck 1, 10 ALU source stuck 1, 11 register write stuck 1 |
| reg_dst | output | 1 | Destination is rd (1) or rt (0) |
| alu_src | output | 1 | Second ALU operand is the immediate |
| mem_to_reg | output | 1 | Write-back takes load data |
| reg_write | output | 1 | Register file write enable |
| mem_read | output | 1 | Data store read strobe |
| mem_write | output | 1 | Data store write enable |
| branch | output | 1 | Conditional branch strobe |
| jump | output | 1 | Absolute jump strobe |
| alu_op | output | 2 | ALU operation class |
| alu_code | output | 4 | ALU function code |
| jr_sel | output | 1 | Next PC taken from rs |
| shamt_sel | output | 1 | First ALU operand is the shift-amount field |
| illegal | output | 1 | Unrecognised instruction |
| alu_result | output | 32 | ALU output |
| alu_zero | output | 1 | ALU result equals zero |
| rs_operand | output | 32 | Value read from register rs |

## Verification
Several properties are checked on every cycle: jump-register and illegal instructions stay quiet when no fault is injected, memory accesses and jumps never overlap, register 0 holds zero, shift decoding agrees with its ALU code, the branch zero flag agrees with operand equality, and each fault select pins its control line. Only the bench's instruction sequences show arithmetic results, load and store round trips, and the state corruption that a stuck enable causes. It reads those results back through later loads and jump-register readouts.

// File: rtl/scdec_pkg.sv
package scdec_pkg;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_LOAD  = 6'b100011;
  localparam logic [5:0] OP_STORE = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_JUMP  = 6'b000010;

  localparam logic [5:0] FN_SLL = 6'b000000;
  localparam logic [5:0] FN_JR  = 6'b001000;
  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_NOR = 6'b100111;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [1:0] {
    AOP_ADD   = 2'b00,
    AOP_SUB   = 2'b01,
    AOP_FUNCT = 2'b10,
    AOP_SHIFT = 2'b11
  } aluop_e;

  typedef enum logic [3:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_ADD = 4'b0010,
    ALU_SUB = 4'b0110,
    ALU_SLT = 4'b0111,
    ALU_NOR = 4'b1100,
    ALU_SLL = 4'b1110
  } alucode_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_MEMW = 2'b01,
    FLT_ASRC = 2'b10,
    FLT_REGW = 2'b11
  } fault_e;

  typedef struct packed {
    logic   reg_dst;
    logic   alu_src;
    logic   mem_to_reg;
    logic   reg_write;
    logic   mem_read;
    logic   mem_write;
    logic   branch;
    logic   jump;
    logic   jr_sel;
    logic   shamt_sel;
    aluop_e alu_op;
  } ctrl_t;

endpackage

// File: rtl/scdec_main_ctrl.sv
module scdec_main_ctrl
  import scdec_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl,
  output logic       illegal
);

  always_comb begin
    ctrl    = '0;
    ctrl.alu_op = AOP_ADD;
    illegal = 1'b0;
    case (opcode)
      OP_RTYPE: begin
        case (funct)
          FN_ADD, FN_SUB, FN_AND, FN_OR, FN_NOR, FN_SLT: begin
            ctrl.reg_dst   = 1'b1;
            ctrl.reg_write = 1'b1;
            ctrl.alu_op    = AOP_FUNCT;
          end
          FN_SLL: begin
            ctrl.reg_dst   = 1'b1;
            ctrl.reg_write = 1'b1;
            ctrl.shamt_sel = 1'b1;
            ctrl.alu_op    = AOP_SHIFT;
          end
          FN_JR: begin
            ctrl.jr_sel = 1'b1;
          end
          default: illegal = 1'b1;
        endcase
      end
      OP_LOAD: begin
        ctrl.alu_src    = 1'b1;
        ctrl.mem_to_reg = 1'b1;
        ctrl.reg_write  = 1'b1;
        ctrl.mem_read   = 1'b1;
      end
      OP_STORE: begin
        ctrl.alu_src   = 1'b1;
        ctrl.mem_write = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.alu_op = AOP_SUB;
      end
      OP_JUMP: begin
        ctrl.jump = 1'b1;
      end
      default: illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/scdec_alu_ctrl.sv
module scdec_alu_ctrl
  import scdec_pkg::*;
(
  input  aluop_e     alu_op,
  input  logic [5:0] funct,
  output alucode_e   code
);

  always_comb begin
    case (alu_op)
      AOP_SUB:   code = ALU_SUB;
      AOP_SHIFT: code = ALU_SLL;
      AOP_FUNCT: begin
        case (funct)
          FN_SUB:  code = ALU_SUB;
          FN_AND:  code = ALU_AND;
          FN_OR:   code = ALU_OR;
          FN_NOR:  code = ALU_NOR;
          FN_SLT:  code = ALU_SLT;
          default: code = ALU_ADD;
        endcase
      end
      default:   code = ALU_ADD;
    endcase
  end

endmodule

// File: rtl/scdec_fault_force.sv
module scdec_fault_force
  import scdec_pkg::*;
(
  input  ctrl_t  ctrl_in,
  input  fault_e mode,
  output ctrl_t  ctrl_out
);

  always_comb begin
    ctrl_out = ctrl_in;
    case (mode)
      FLT_MEMW: ctrl_out.mem_write = 1'b1;
      FLT_ASRC: ctrl_out.alu_src   = 1'b1;
      FLT_REGW: ctrl_out.reg_write = 1'b1;
      default:  ctrl_out = ctrl_in;
    endcase
  end

endmodule

// File: rtl/scdec_alu.sv
module scdec_alu
  import scdec_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  alucode_e     code,
  output logic [W-1:0] result,
  output logic         zero
);

  localparam int SH_W = $clog2(W);

  always_comb begin
    case (code)
      ALU_AND: result = op_a & op_b;
      ALU_OR:  result = op_a | op_b;
      ALU_SUB: result = op_a - op_b;
      ALU_SLT: result = W'($signed(op_a) < $signed(op_b));
      ALU_NOR: result = ~(op_a | op_b);
      ALU_SLL: result = op_b << op_a[SH_W-1:0];
      default: result = op_a + op_b;
    endcase
  end

  assign zero = (result == '0);

endmodule

// File: rtl/scdec_regfile.sv
module scdec_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);

  logic [NREG-1:0][W-1:0] rf_q, rf_d;

  always_comb begin
    rf_d = rf_q;
    if (we && (wa != '0)) rf_d[wa] = wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rf_q <= '0;
    else if (we) rf_q <= rf_d;
  end

  assign rd_a = rf_q[ra_a];
  assign rd_b = rf_q[ra_b];

  a_r6_zero_reg_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rf_q[0] == '0);

endmodule

// File: rtl/scdec_dmem.sv
module scdec_dmem #(
  parameter int         W     = 32,
  parameter int         DEPTH = 16,
  parameter logic [W-1:0] SEED = 32'h100,
  localparam int        AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [W-1:0]  wd,
  output logic [W-1:0]  rd
);

  logic [DEPTH-1:0][W-1:0] mem_q, mem_d;

  always_comb begin
    mem_d = mem_q;
    if (we) mem_d[addr] = wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= SEED + W'(i * 4);
    end else if (we) begin
      mem_q <= mem_d;
    end
  end

  assign rd = mem_q[addr];

endmodule

// File: rtl/scdec_core.sv
module scdec_core
  import scdec_pkg::*;
#(
  parameter int             DATA_W     = 32,
  parameter int             DMEM_WORDS = 16,
  parameter logic [DATA_W-1:0] DMEM_SEED = 32'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       instr,
  input  logic [1:0]        fault_sel,
  output logic              reg_dst,
  output logic              alu_src,
  output logic              mem_to_reg,
  output logic              reg_write,
  output logic              mem_read,
  output logic              mem_write,
  output logic              branch,
  output logic              jump,
  output logic [1:0]        alu_op,
  output logic [3:0]        alu_code,
  output logic              jr_sel,
  output logic              shamt_sel,
  output logic              illegal,
  output logic [DATA_W-1:0] alu_result,
  output logic              alu_zero,
  output logic [DATA_W-1:0] rs_operand
);

  localparam int REG_AW   = 5;
  localparam int NUM_REGS = 1 << REG_AW;
  localparam int DM_AW    = $clog2(DMEM_WORDS);
  localparam int WORD_LSB = 2;

  logic [5:0]        f_op, f_fn;
  logic [REG_AW-1:0] f_rs, f_rt, f_rd;
  logic [4:0]        f_sh;
  logic [15:0]       f_imm;

  assign f_op  = instr[31:26];
  assign f_rs  = instr[25:21];
  assign f_rt  = instr[20:16];
  assign f_rd  = instr[15:11];
  assign f_sh  = instr[10:6];
  assign f_fn  = instr[5:0];
  assign f_imm = instr[15:0];

  ctrl_t    dec_ctrl, ctrl;
  alucode_e code;
  logic     dec_illegal;

  scdec_main_ctrl u_main (
    .opcode  (f_op),
    .funct   (f_fn),
    .ctrl    (dec_ctrl),
    .illegal (dec_illegal)
  );

  scdec_fault_force u_force (
    .ctrl_in  (dec_ctrl),
    .mode     (fault_e'(fault_sel)),
    .ctrl_out (ctrl)
  );

  scdec_alu_ctrl u_aluc (
    .alu_op (ctrl.alu_op),
    .funct  (f_fn),
    .code   (code)
  );

  logic [DATA_W-1:0] rs_val, rt_val, imm_ext, op_a, op_b, ld_data, wb_data;
  logic [REG_AW-1:0] wb_addr;

  assign imm_ext = {{(DATA_W-16){f_imm[15]}}, f_imm};
  assign op_a    = ctrl.shamt_sel ? DATA_W'(f_sh) : rs_val;
  assign op_b    = ctrl.alu_src   ? imm_ext       : rt_val;
  assign wb_addr = ctrl.reg_dst   ? f_rd          : f_rt;
  assign wb_data = ctrl.mem_to_reg ? ld_data      : alu_result;

  scdec_regfile #(.W(DATA_W), .NREG(NUM_REGS)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .ra_a  (f_rs),
    .ra_b  (f_rt),
    .rd_a  (rs_val),
    .rd_b  (rt_val),
    .we    (ctrl.reg_write),
    .wa    (wb_addr),
    .wd    (wb_data)
  );

  scdec_alu #(.W(DATA_W)) u_alu (
    .op_a   (op_a),
    .op_b   (op_b),
    .code   (code),
    .result (alu_result),
    .zero   (alu_zero)
  );

  scdec_dmem #(.W(DATA_W), .DEPTH(DMEM_WORDS), .SEED(DMEM_SEED)) u_dm (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (alu_result[WORD_LSB +: DM_AW]),
    .we    (ctrl.mem_write),
    .wd    (rt_val),
    .rd    (ld_data)
  );

  assign reg_dst    = ctrl.reg_dst;
  assign alu_src    = ctrl.alu_src;
  assign mem_to_reg = ctrl.mem_to_reg;
  assign reg_write  = ctrl.reg_write;
  assign mem_read   = ctrl.mem_read;
  assign mem_write  = ctrl.mem_write;
  assign branch     = ctrl.branch;
  assign jump       = ctrl.jump;
  assign alu_op     = ctrl.alu_op;
  assign alu_code   = code;
  assign jr_sel     = ctrl.jr_sel;
  assign shamt_sel  = ctrl.shamt_sel;
  assign illegal    = dec_illegal;
  assign rs_operand = rs_val;

  // R3: jump-register leaves state alone when no fault is injected
  a_r3_jr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (jr_sel && fault_sel == FLT_NONE) |->
      (!reg_write && !mem_write && !mem_read && !branch && !jump));

  // R5: illegal instructions drive no enable
  a_r5_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal && fault_sel == FLT_NONE) |->
      (!reg_write && !mem_write && !mem_read && !branch && !jump && !jr_sel));

  // R1: at most one of the access and flow strobes at a time
  a_r1_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_sel == FLT_NONE) |-> $onehot0({mem_read, mem_write, branch, jump, jr_sel}));

  // R4: shift select pairs with the shift class and code
  a_r4_shift_code: assert property (@(posedge clk) disable iff (!rst_n)
    shamt_sel |-> (alu_op == 2'b11 && alu_code == 4'b1110 && reg_dst));

  // R10: zero flag on a branch means the operands matched
  a_r10_beq_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (branch && fault_sel == FLT_NONE) |-> (alu_zero == (rs_val == rt_val)));

  // R7 / R8 / R9: each fault select pins its line
  a_r7_memw_pinned: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_sel == FLT_MEMW) |-> mem_write);
  a_r8_asrc_pinned: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_sel == FLT_ASRC) |-> alu_src);
  a_r9_regw_pinned: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_sel == FLT_REGW) |-> reg_write);

endmodule

// File: tb/tb_scdec_core.sv
module tb_scdec_core;

  logic        clk;
  logic        rst_n;
  logic [31:0] instr;
  logic [1:0]  fault_sel;
  logic        reg_dst, alu_src, mem_to_reg, reg_write, mem_read, mem_write;
  logic        branch, jump, jr_sel, shamt_sel, illegal, alu_zero;
  logic [1:0]  alu_op;
  logic [3:0]  alu_code;
  logic [31:0] alu_result, rs_operand;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  scdec_core dut (
    .clk(clk), .rst_n(rst_n), .instr(instr), .fault_sel(fault_sel),
    .reg_dst(reg_dst), .alu_src(alu_src), .mem_to_reg(mem_to_reg),
    .reg_write(reg_write), .mem_read(mem_read), .mem_write(mem_write),
    .branch(branch), .jump(jump), .alu_op(alu_op), .alu_code(alu_code),
    .jr_sel(jr_sel), .shamt_sel(shamt_sel), .illegal(illegal),
    .alu_result(alu_result), .alu_zero(alu_zero), .rs_operand(rs_operand)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] rtype(input int rs, input int rt, input int rd,
                                        input int sh, input logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'(sh), fn};
  endfunction

  function automatic logic [31:0] itype(input logic [5:0] op, input int rs,
                                        input int rt, input int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  // order: dst src m2r rw mr mw br j jr sh ill | op(2) | code(4)
  function automatic logic [16:0] ctl();
    return {reg_dst, alu_src, mem_to_reg, reg_write, mem_read, mem_write,
            branch, jump, jr_sel, shamt_sel, illegal, alu_op, alu_code};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] i, input logic [1:0] f = 2'b00);
    @(negedge clk);
    instr     = i;
    fault_sel = f;
    #1;
  endtask

  task automatic read_reg(input string req, input int r, input logic [31:0] exp);
    apply(rtype(r, 0, 0, 0, 6'b001000));
    chk(req, rs_operand, exp);
  endtask

  task automatic t_reset();
    apply(32'h0);
    chk("R4 reset all-zero decode", 32'(ctl()), 32'(17'b1_0_0_1_0_0_0_0_0_1_0_11_1110));
    chk("R11 reset regs zero", alu_result, 32'h0);
    read_reg("R11 reset r0", 0, 32'h0);
    read_reg("R11 reset r31", 31, 32'h0);
  endtask

  task automatic t_load_store();
    apply(itype(6'b100011, 0, 1, 0));
    chk("R1 load ctrl", 32'(ctl()), 32'(17'b0_1_1_1_1_0_0_0_0_0_0_00_0010));
    apply(itype(6'b100011, 0, 2, 4));
    read_reg("R11 seed word0", 1, 32'h100);
    read_reg("R11 seed word1", 2, 32'h104);
  endtask

  task automatic t_rformat();
    apply(rtype(1, 2, 3, 0, 6'b100000));
    chk("R2 add ctrl", 32'(ctl()), 32'(17'b1_0_0_1_0_0_0_0_0_0_0_10_0010));
    chk("R2 add result", alu_result, 32'h204);
    apply(rtype(1, 2, 4, 0, 6'b100010));
    chk("R2 sub code", 32'(alu_code), 32'h6);
    chk("R2 sub result", alu_result, 32'hFFFF_FFFC);
    apply(rtype(1, 2, 13, 0, 6'b100100));
    chk("R2 and code", 32'(alu_code), 32'h0);
    chk("R2 and result", alu_result, 32'h100);
    apply(rtype(1, 2, 13, 0, 6'b100101));
    chk("R2 or code", 32'(alu_code), 32'h1);
    chk("R2 or result", alu_result, 32'h104);
    apply(rtype(1, 2, 13, 0, 6'b100111));
    chk("R2 nor code", 32'(alu_code), 32'hC);
    chk("R2 nor result", alu_result, 32'hFFFF_FEFB);
    apply(rtype(1, 2, 13, 0, 6'b101010));
    chk("R2 slt code", 32'(alu_code), 32'h7);
    chk("R2 slt true", alu_result, 32'h1);
    apply(rtype(2, 1, 13, 0, 6'b101010));
    chk("R2 slt false", alu_result, 32'h0);
    apply(rtype(4, 1, 12, 0, 6'b101010));
    chk("R2 slt signed", alu_result, 32'h1);
    read_reg("R2 add written back", 3, 32'h204);
    read_reg("R2 sub written back", 4, 32'hFFFF_FFFC);
  endtask

  task automatic t_shift();
    apply(rtype(0, 2, 5, 4, 6'b000000));
    chk("R4 sll ctrl", 32'(ctl()), 32'(17'b1_0_0_1_0_0_0_0_0_1_0_11_1110));
    chk("R4 sll result", alu_result, 32'h1040);
    apply(rtype(0, 2, 0, 4, 6'b000000));
    read_reg("R4 sll written back", 5, 32'h1040);
    read_reg("R6 r0 stays zero", 0, 32'h0);
  endtask

  task automatic t_store();
    apply(itype(6'b101011, 0, 3, 8));
    chk("R1 store ctrl", 32'(ctl()), 32'(17'b0_1_0_0_0_1_0_0_0_0_0_00_0010));
    apply(itype(6'b100011, 0, 6, 8));
    read_reg("R11 store then load", 6, 32'h204);
  endtask

  task automatic t_flow();
    apply(itype(6'b000100, 1, 1, 0));
    chk("R10 beq ctrl", 32'(ctl()), 32'(17'b0_0_0_0_0_0_1_0_0_0_0_01_0110));
    chk("R10 beq zero equal", 32'(alu_zero), 32'h1);
    apply(itype(6'b000100, 1, 2, 0));
    chk("R10 beq zero differ", 32'(alu_zero), 32'h0);
    apply({6'b000010, 26'h3FF_FFFF});
    chk("R1 jump ctrl", 32'(ctl()), 32'(17'b0_0_0_0_0_0_0_1_0_0_0_00_0010));
    apply(rtype(2, 0, 0, 0, 6'b001000));
    chk("R3 jr ctrl", 32'(ctl()), 32'(17'b0_0_0_0_0_0_0_0_1_0_0_00_0010));
    chk("R3 jr target", rs_operand, 32'h104);
    read_reg("R10 beq leaves r1", 1, 32'h100);
  endtask

  task automatic t_illegal();
    apply(itype(6'b111111, 0, 1, 0));
    chk("R5 bad opcode", 32'(ctl()), 32'(17'b0_0_0_0_0_0_0_0_0_0_1_00_0010));
    apply(rtype(2, 2, 1, 0, 6'b111111));
    chk("R5 bad funct", 32'(ctl()), 32'(17'b0_0_0_0_0_0_0_0_0_0_1_00_0010));
    read_reg("R5 no write on illegal", 1, 32'h100);
  endtask

  task automatic t_faults();
    apply(rtype(1, 2, 10, 0, 6'b100000), 2'b10);
    chk("R8 alu src pinned", 32'(alu_src), 32'h1);
    chk("R8 add uses immediate", alu_result, 32'h5120);
    apply(rtype(1, 2, 5, 0, 6'b100100), 2'b01);
    chk("R7 memw pinned on R-format", 32'(mem_write), 32'h1);
    apply(itype(6'b100011, 0, 11, 0));
    read_reg("R7 R-format corrupts word0", 11, 32'h104);
    apply(itype(6'b100011, 0, 7, 12), 2'b01);
    apply(itype(6'b100011, 0, 8, 12));
    read_reg("R7 load corrupts word3", 8, 32'h0);
    apply(itype(6'b000100, 1, 2, 0), 2'b01);
    apply(itype(6'b100011, 0, 9, 60));
    read_reg("R7 beq corrupts word15", 9, 32'h104);
    apply(itype(6'b101011, 0, 3, 16), 2'b11);
    chk("R9 regw pinned on store", 32'(reg_write), 32'h1);
    read_reg("R9 store corrupts rt", 3, 32'h10);
    apply(itype(6'b000100, 1, 1, 0), 2'b11);
    read_reg("R9 beq corrupts rt", 1, 32'h0);
  endtask

  initial begin
    instr     = 32'h0;
    fault_sel = 2'b00;
    rst_n     = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_load_store();
    t_rformat();
    t_shift();
    t_store();
    t_flow();
    t_illegal();
    t_faults();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule